// File: doc/BRIEF.md
# Selectable-Ratio Frequency Error Detector

This block measures a local output clock against a slow reference pulse train, such as a tick derived from a USB start-of-frame. It counts output clock cycles between successive rising edges of the reference and subtracts an expected count. The expected count is chosen at run time by a select input: 1536 cycles for a nominal 8 kHz reference, or 3072 cycles for a nominal 4 kHz reference. Both settings correspond to a 12.288 MHz clock. Each measured period produces a signed error word with a one-cycle valid strobe. A frequency-lock loop uses this word to steer its oscillator.

The reference is asynchronous to the counted clock. Its high time can be as short as 250 ns or much longer, so only its rising edge is used. A tolerance window with hysteresis produces a lock flag. A watchdog on the period count raises a reference-missing flag when edges stop arriving. A change of the select input discards the period in progress and drops lock.

Top module: `freq_err_det`

## Requirements
- R1: After reset, err_o is 0 and valid_o, lock_o and missing_o are low. The first reference rising edge after reset only starts a measurement and produces no valid_o.
- R2: With sel_i high the expected count is 1536; with sel_i low it is 3072. The measured count is the number of clk_i rising edges between two successive synchronized reference rising edges. err_o is measured minus expected, as a 16-bit two's complement value.
- R3: Only the rising edge of ref_i is timed, so the pulse high time has no effect on err_o. valid_o is high for exactly one cycle per measured period.
- R4: lock_o rises after 4 consecutive measured periods with |err_o| <= 4. Any period outside that window before the fourth restarts the run.
- R5: Once locked, lock_o falls only after 2 consecutive periods with |err_o| > 4. A single out-of-window period followed by an in-window one keeps lock.
- R6: If more than twice the expected count passes with no reference edge, missing_o rises, lock_o clears and no valid_o is produced for that period. The next edge clears missing_o and only restarts measurement. A period of exactly twice the expected count is still measured normally.
- R7: A change of sel_i clears lock_o and discards the period in progress. The first edge after the change produces no valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counted output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Asynchronous reference pulse train |
| sel_i | input | 1 | Ratio select: 1 = 1536 cycles, 0 = 3072 cycles |
| err_o | output | 16 | Signed error, measured minus expected count |
| valid_o | output | 1 | One-cycle strobe when err_o is updated |
| lock_o | output | 1 | Error held inside the tolerance window |
| missing_o | output | 1 | Reference edges absent beyond twice the expected period |

## Verification
The hardest states to reach are those that depend on history across many long periods. Examples are the exit from lock, which needs two consecutive bad periods, and the sequence of missing reference, recovery and re-arming. The bench therefore drives reference edges at exact cycle spacings. It captures each error word together with the lock state one cycle later.

Period lengths are chosen to land on either side of the ±4 window and exactly on the twice-expected missing boundary. A select change is placed in the middle of a period, so that the discarded measurement shows up as one missing strobe rather than as a wrong error.

// File: rtl/fed_pkg.sv
package fed_pkg;
  localparam int unsigned ERR_W_DEF = 16;
  localparam int unsigned CNT_W_DEF = 16;

  function automatic logic [ERR_W_DEF-1:0] mag_of(input logic [ERR_W_DEF-1:0] v);
    return v[ERR_W_DEF-1] ? (~v + ERR_W_DEF'(1)) : v;
  endfunction
endpackage

// File: rtl/fed_ref_sync.sv
module fed_ref_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  localparam int unsigned SW = SYNC_N + 1;

  logic [SW-1:0] stg_q;

  generate
    if (SYNC_N < 2) begin : g_bad
      initial $error("fed_ref_sync: SYNC_N must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[SW-2:0], ref_i};
  end

  assign rise_o = stg_q[SW-2] & ~stg_q[SW-1];

  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fed_period_meter.sv
module fed_period_meter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ERR_W  = 16,
  parameter int unsigned EXP_LO = 3072,
  parameter int unsigned EXP_HI = 1536
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             sel_i,
  output logic [ERR_W-1:0] err_o,
  output logic             valid_o,
  output logic             missing_o,
  output logic             clear_o
);
  localparam logic [CNT_W-1:0] EXP_LO_C = CNT_W'(EXP_LO);
  localparam logic [CNT_W-1:0] EXP_HI_C = CNT_W'(EXP_HI);

  logic             sel_q, armed_q;
  logic [CNT_W-1:0] cnt_q, exp_cnt, limit;
  logic             sel_chg, miss_hit;

  assign exp_cnt  = sel_q ? EXP_HI_C : EXP_LO_C;
  assign limit    = {exp_cnt[CNT_W-2:0], 1'b0};
  assign sel_chg  = sel_i != sel_q;
  assign miss_hit = armed_q && !rise_i && (cnt_q == limit);
  assign clear_o  = sel_chg | miss_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      err_o     <= '0;
      valid_o   <= 1'b0;
      missing_o <= 1'b0;
    end else begin
      sel_q   <= sel_i;
      valid_o <= 1'b0;
      if (sel_chg) begin
        // period in progress is thrown away
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (rise_i) begin
        missing_o <= 1'b0;
        armed_q   <= 1'b1;
        cnt_q     <= CNT_W'(1);
        if (armed_q) begin
          valid_o <= 1'b1;
          err_o   <= ERR_W'(cnt_q) - ERR_W'(exp_cnt);
        end
      end else if (armed_q) begin
        if (cnt_q == limit) begin
          missing_o <= 1'b1;
          armed_q   <= 1'b0;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_valid_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);
  assert_no_valid_missing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missing_o |-> !valid_o);
  assert_sel_discard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_chg |=> !valid_o);
endmodule

// File: rtl/fed_lock_judge.sv
module fed_lock_judge #(
  parameter int unsigned ERR_W    = 16,
  parameter int unsigned TOL      = 4,
  parameter int unsigned LOCK_IN  = 4,
  parameter int unsigned LOCK_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             clear_i,
  output logic             lock_o
);
  localparam int unsigned GW = $clog2(LOCK_IN + 1);
  localparam int unsigned BW = $clog2(LOCK_OUT + 1);

  logic [GW-1:0]    good_q;
  logic [BW-1:0]    bad_q;
  logic [ERR_W-1:0] mag;
  logic             in_win;

  assign mag    = err_i[ERR_W-1] ? (~err_i + ERR_W'(1)) : err_i;
  assign in_win = mag <= ERR_W'(TOL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else if (clear_i) begin
      lock_o <= 1'b0;
      good_q <= '0;
      bad_q  <= '0;
    end else if (valid_i) begin
      if (in_win) begin
        bad_q <= '0;
        if (!lock_o) begin
          if (good_q + GW'(1) == GW'(LOCK_IN)) begin
            lock_o <= 1'b1;
            good_q <= '0;
          end else begin
            good_q <= good_q + GW'(1);
          end
        end
      end else begin
        good_q <= '0;
        if (lock_o) begin
          if (bad_q + BW'(1) == BW'(LOCK_OUT)) begin
            lock_o <= 1'b0;
            bad_q  <= '0;
          end else begin
            bad_q <= bad_q + BW'(1);
          end
        end
      end
    end
  end

  assert_clear_drops_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !lock_o);
  assert_lock_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(valid_i));
  assert_lock_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(in_win));
  assert_unlock_needs_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock_o) && !$past(clear_i)) |-> ($past(valid_i) && !$past(in_win)));
endmodule

// File: rtl/freq_err_det.sv
module freq_err_det #(
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned CNT_W    = fed_pkg::CNT_W_DEF,
  parameter int unsigned ERR_W    = fed_pkg::ERR_W_DEF,
  parameter int unsigned EXP_LO   = 3072,
  parameter int unsigned EXP_HI   = 1536,
  parameter int unsigned TOL      = 4,
  parameter int unsigned LOCK_IN  = 4,
  parameter int unsigned LOCK_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             sel_i,
  output logic [ERR_W-1:0] err_o,
  output logic             valid_o,
  output logic             lock_o,
  output logic             missing_o
);
  logic rise, clear;

  fed_ref_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .rise_o(rise)
  );

  fed_period_meter #(
    .CNT_W(CNT_W), .ERR_W(ERR_W), .EXP_LO(EXP_LO), .EXP_HI(EXP_HI)
  ) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .sel_i(sel_i),
    .err_o(err_o), .valid_o(valid_o), .missing_o(missing_o), .clear_o(clear)
  );

  fed_lock_judge #(
    .ERR_W(ERR_W), .TOL(TOL), .LOCK_IN(LOCK_IN), .LOCK_OUT(LOCK_OUT)
  ) u_judge (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_o), .err_i(err_o),
    .clear_i(clear), .lock_o(lock_o)
  );

  assert_missing_unlocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(missing_o) |-> !lock_o);
endmodule

// File: tb/freq_err_det_tb_top.sv
module freq_err_det_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_s = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] err;
  logic        valid, lock, missing;

  int total = 0, bad = 0;
  int cap_n = 0, dbl = 0, cyc = 0;
  int cap_err [64];
  int cap_lk  [64];
  int ee [64];
  int el [64];
  logic pend = 1'b0, prev_v = 1'b0;

  always #4 clk = ~clk;

  freq_err_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .sel_i(sel),
    .err_o(err), .valid_o(valid), .lock_o(lock), .missing_o(missing)
  );

  // capture each error word and the lock state one cycle after it
  always @(negedge clk) begin
    if (pend) begin
      if (cap_n >= 1 && cap_n <= 64) cap_lk[cap_n-1] = int'(lock);
      pend = 1'b0;
    end
    if (valid) begin
      if (prev_v) dbl++;
      if (cap_n < 64) cap_err[cap_n] = int'($signed(err));
      cap_n++;
      pend = 1'b1;
    end
    prev_v = valid;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_caps();
    cap_n = 0;
    dbl   = 0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    ref_s = 1'b0;
    sel   = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_caps();
  endtask

  // rising edge now, next rising edge exactly per cycles later
  task automatic pulse(input int per, input int w);
    ref_s = 1'b1;
    repeat (w) @(negedge clk);
    ref_s = 1'b0;
    repeat (per - w) @(negedge clk);
  endtask

  task automatic closer();
    pulse(12, 3);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_seq(input string tag, input int n);
    chk({tag, " count"}, cap_n, n);
    for (int i = 0; i < n && i < 64; i++) begin
      chk({tag, " err"}, cap_err[i], ee[i]);
      chk({tag, " lock"}, cap_lk[i], el[i]);
    end
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R1 reset err", int'(err), 0);
    chk("R1 reset valid", int'(valid), 0);
    chk("R1 reset lock", int'(lock), 0);
    chk("R1 reset missing", int'(missing), 0);
    pulse(100, 3);
    chk("R1 first edge no valid", cap_n, 0);
  endtask

  task automatic t_lock_hi();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) pulse(1536, 3);
    closer();
    for (int i = 0; i < 4; i++) begin ee[i] = 0; el[i] = (i == 3) ? 1 : 0; end
    check_seq("R2 R4 sel high nominal", 4);
  endtask

  task automatic t_unlock();
    int per [10] = '{1536, 1536, 1536, 1536, 1540, 1532, 1541, 1536, 1541, 1530};
    int er  [10] = '{0, 0, 0, 0, 4, -4, 5, 0, 5, -6};
    int lk  [10] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 0};
    do_reset(1'b1);
    for (int i = 0; i < 10; i++) pulse(per[i], 3);
    closer();
    for (int i = 0; i < 10; i++) begin ee[i] = er[i]; el[i] = lk[i]; end
    check_seq("R5 R2 signed error and unlock", 10);
  endtask

  task automatic t_consec_lo();
    int per [8] = '{3072, 3072, 3072, 3080, 3072, 3072, 3072, 3069};
    int er  [8] = '{0, 0, 0, 8, 0, 0, 0, -3};
    int lk  [8] = '{0, 0, 0, 0, 0, 0, 0, 1};
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) pulse(per[i], 3);
    closer();
    for (int i = 0; i < 8; i++) begin ee[i] = er[i]; el[i] = lk[i]; end
    check_seq("R4 R2 sel low consecutive run", 8);
  endtask

  task automatic t_width();
    do_reset(1'b1);
    pulse(1537, 1);
    pulse(1535, 1000);
    pulse(1536, 1);
    closer();
    ee[0] = 1;  el[0] = 0;
    ee[1] = -1; el[1] = 0;
    ee[2] = 0;  el[2] = 0;
    check_seq("R3 pulse width ignored", 3);
    chk("R3 single-cycle valid", dbl, 0);
  endtask

  task automatic t_missing();
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) pulse(1536, 3);
    pulse(3072, 3);
    pulse(3200, 3);
    for (int i = 0; i < 4; i++) begin ee[i] = 0; el[i] = (i == 3) ? 1 : 0; end
    ee[4] = 1536; el[4] = 1;
    check_seq("R6 boundary period measured", 5);
    chk("R6 missing raised", int'(missing), 1);
    chk("R6 lock cleared", int'(lock), 0);
    clear_caps();
    pulse(1536, 3);
    pulse(1536, 3);
    closer();
    ee[0] = 0; el[0] = 0;
    ee[1] = 0; el[1] = 0;
    check_seq("R6 recovery re-arms", 2);
    chk("R6 missing cleared", int'(missing), 0);
  endtask

  task automatic t_sel_change();
    do_reset(1'b1);
    for (int i = 0; i < 5; i++) pulse(1536, 3);
    pulse(500, 3);
    sel = 1'b0;
    repeat (1000) @(negedge clk);
    for (int i = 0; i < 5; i++) begin ee[i] = 0; el[i] = (i >= 3) ? 1 : 0; end
    check_seq("R7 before select change", 5);
    chk("R7 lock cleared on select change", int'(lock), 0);
    clear_caps();
    for (int i = 0; i < 3; i++) pulse(3072, 3);
    closer();
    for (int i = 0; i < 3; i++) begin ee[i] = 0; el[i] = 0; end
    check_seq("R7 first edge discarded", 3);
  endtask

  initial begin
    t_reset();
    t_lock_hi();
    t_unlock();
    t_consec_lo();
    t_width();
    t_missing();
    t_sel_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule